// File: doc/BRIEF.md
# Doze CPU Clock Ratio Generator

This block lets a CPU run slower than the peripherals while everything stays in one synchronous clock domain. The system clock never changes. The block instead produces a clock-enable strobe that the CPU pipeline qualifies its registers with. Peripherals keep running from the full system clock, so their bit rates and timers are not affected when the CPU is slowed. For example, a 1:4 setting turns a 20 MIPS core into a 5 MIPS core while a serial link keeps its rate.

A 16-bit control word sets the behaviour. One bit turns doze on. A 3-bit code n picks a divide of 2^n, from 1:1 up to 1:128. A further bit arms an automatic return to full speed. When that bit is armed, an interrupt event clears the doze-on bit in hardware and the CPU gets its full rate back on the next cycle. A change of ratio restarts the divider phase, so the CPU never sees two strobes closer together than the ratio in force.

Top module: `doze_ratio_gen`

## Requirements
- R1: During and straight after reset the control word reads 0x0000 (doze off, code 0, return-on-interrupt off) and `cpu_ce` is high on every cycle.
- R2: Field layout of the control word: bit 15 is return-on-interrupt, bits 14:12 hold the ratio code, bit 11 is doze-on. All other bits are not stored and read as 0. A write is visible on `cfg_rd_data` in the cycle after the write edge.
- R3: While doze-on is 0, `cpu_ce` is high on every cycle whatever the ratio code holds.
- R4: While doze-on is 1 with code n (0..7), `cpu_ce` is high for exactly one cycle in every 2^n cycles, so 1:1 with n=0 and 1:128 with n=7.
- R5: On the write that sets doze-on, counting the cycle after that write edge as cycle 0, `cpu_ce` is high in cycles k where k mod 2^n equals 2^n-1, and low in all other cycles.
- R6: A write that changes the ratio code while doze is on restarts the phase exactly as in R5, using the new code. No gap between strobes is then shorter than 2^n of the new code.
- R7: With doze-on and return-on-interrupt both 1, a cycle with `irq_event` high clears doze-on at the next edge. From then on `cpu_ce` stays high. The ratio code and return-on-interrupt keep their values.
- R8: With return-on-interrupt 0, `irq_event` has no effect: doze-on stays 1 and the strobe phase continues unbroken.
- R9: If the hardware clear of R7 and a register write fall in the same cycle, the ratio code and return-on-interrupt come from the write, and doze-on ends up 0.
- R10: A write that leaves doze-on at 1 and leaves the ratio code unchanged does not disturb the strobe phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, shared with the peripherals |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the control word |
| cfg_wr_data | input | 16 | Control word value to write |
| cfg_rd_data | output | 16 | Current control word |
| irq_event | input | 1 | Interrupt event; one cycle high per event |
| cpu_ce | output | 1 | CPU clock-enable strobe |

## Verification
The hardest case to reach is the phase restart. A ratio change must land in the middle of a running period, and at 1:128 the sweep has to cover a whole period to see the next strobe. The bench enables a slow ratio, waits a few cycles so the divider is partway through a period, then writes a new code. It then compares every following cycle against the modulo formula counted from that write. The same method is used for a coincident write and interrupt, and for a rewrite of an unchanged code.

// File: rtl/doze_pkg.sv
package doze_pkg;
  // width of the ratio code
  localparam int CODE_W = 3;
  // the divider must hold 2^(2^CODE_W - 1) - 1
  localparam int CNT_W  = (1 << CODE_W) - 1;

  typedef struct packed {
    logic              roi;
    logic [CODE_W-1:0] ratio;
    logic              en;
  } doze_cfg_t;

  // last count value of a period for code n: 2^n - 1
  function automatic logic [CNT_W-1:0] period_last(input logic [CODE_W-1:0] code);
    logic [CNT_W:0] span;
    span = ((CNT_W+1)'(1) << code) - (CNT_W+1)'(1);
    return span[CNT_W-1:0];
  endfunction
endpackage

// File: rtl/doze_cfg_reg.sv
module doze_cfg_reg
  import doze_pkg::*;
#(
  parameter int REG_W     = 16,
  parameter int EN_BIT    = 11,
  parameter int RATIO_LSB = 12,
  parameter int ROI_BIT   = 15
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             irq_event,
  output doze_cfg_t        cfg_q,
  output doze_cfg_t        cfg_d,
  output logic             hw_clear
);
  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      cfg_d.en    = wr_data[EN_BIT];
      cfg_d.ratio = wr_data[RATIO_LSB +: CODE_W];
      cfg_d.roi   = wr_data[ROI_BIT];
    end
    hw_clear = irq_event & cfg_q.en & cfg_q.roi;
    if (hw_clear) cfg_d.en = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end
endmodule

// File: rtl/doze_div_counter.sv
module doze_div_counter
  import doze_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_q,
  input  logic [CODE_W-1:0] ratio_q,
  input  logic [CODE_W-1:0] ratio_d,
  output logic              tick,
  output logic              restart
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    // while doze is off the counter is held at the reload of the next code
    restart = !en_q || (ratio_d != ratio_q);
    tick    = (cnt_q == '0);
    if (restart)   cnt_d = period_last(ratio_d);
    else if (tick) cnt_d = period_last(ratio_q);
    else           cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/doze_readback.sv
module doze_readback
  import doze_pkg::*;
#(
  parameter int REG_W     = 16,
  parameter int EN_BIT    = 11,
  parameter int RATIO_LSB = 12,
  parameter int ROI_BIT   = 15
)(
  input  doze_cfg_t        cfg_q,
  output logic [REG_W-1:0] rd_data
);
  always_comb begin
    rd_data                       = '0;
    rd_data[EN_BIT]               = cfg_q.en;
    rd_data[RATIO_LSB +: CODE_W]  = cfg_q.ratio;
    rd_data[ROI_BIT]              = cfg_q.roi;
  end
endmodule

// File: rtl/doze_ratio_gen.sv
module doze_ratio_gen
  import doze_pkg::*;
#(
  parameter int REG_W     = 16,
  parameter int EN_BIT    = 11,
  parameter int RATIO_LSB = 12,
  parameter int ROI_BIT   = 15
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [REG_W-1:0] cfg_wr_data,
  output logic [REG_W-1:0] cfg_rd_data,
  input  logic             irq_event,
  output logic             cpu_ce
);
  doze_cfg_t         cfg_q, cfg_d;
  logic              hw_clear;
  logic              div_tick;
  logic              phase_restart;
  logic              doze_en;
  logic              roi_arm;
  logic [CODE_W-1:0] ratio_code;

  doze_cfg_reg #(
    .REG_W(REG_W), .EN_BIT(EN_BIT), .RATIO_LSB(RATIO_LSB), .ROI_BIT(ROI_BIT)
  ) cfg_i (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .irq_event(irq_event), .cfg_q(cfg_q), .cfg_d(cfg_d), .hw_clear(hw_clear)
  );

  doze_div_counter div_i (
    .clk(clk), .rst_n(rst_n), .en_q(cfg_q.en), .ratio_q(cfg_q.ratio),
    .ratio_d(cfg_d.ratio), .tick(div_tick), .restart(phase_restart)
  );

  doze_readback #(
    .REG_W(REG_W), .EN_BIT(EN_BIT), .RATIO_LSB(RATIO_LSB), .ROI_BIT(ROI_BIT)
  ) rb_i (
    .cfg_q(cfg_q), .rd_data(cfg_rd_data)
  );

  assign doze_en    = cfg_q.en;
  assign roi_arm    = cfg_q.roi;
  assign ratio_code = cfg_q.ratio;
  assign cpu_ce     = !doze_en || div_tick;
endmodule

// File: rtl/doze_ratio_gen_chk.sv
module doze_ratio_gen_chk
  import doze_pkg::*;
#(
  parameter int REG_W     = 16,
  parameter int EN_BIT    = 11,
  parameter int RATIO_LSB = 12,
  parameter int ROI_BIT   = 15
)(
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_en,
  input logic [REG_W-1:0]  cfg_rd_data,
  input logic              irq_event,
  input logic              cpu_ce,
  input logic              doze_en,
  input logic              roi_arm,
  input logic [CODE_W-1:0] ratio_code,
  input logic              hw_clear
);
  localparam int GAP_W = CNT_W + 2;
  logic [GAP_W-1:0] gap_q;
  logic [REG_W-1:0] rsvd_mask;

  always_comb begin
    rsvd_mask                      = '1;
    rsvd_mask[EN_BIT]              = 1'b0;
    rsvd_mask[RATIO_LSB +: CODE_W] = '0;
    rsvd_mask[ROI_BIT]             = 1'b0;
  end

  // cycles since the previous strobe, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            gap_q <= GAP_W'(1);
    else if (cpu_ce)       gap_q <= GAP_W'(1);
    else if (gap_q != '1)  gap_q <= gap_q + GAP_W'(1);
  end

  AST_FULL_SPEED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !doze_en |-> cpu_ce); // R3
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_data & rsvd_mask) == '0); // R2
  AST_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ce && doze_en) |-> (gap_q >= (GAP_W'(1) << ratio_code))); // R6
  AST_ROI_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_event && doze_en && roi_arm) |=> !doze_en); // R7
  AST_ROI_CLEAR_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    hw_clear |-> (irq_event && roi_arm)); // R7
  AST_IRQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_event && doze_en && !roi_arm && !cfg_wr_en) |=> doze_en); // R8
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr_en && !hw_clear) |=> $stable(cfg_rd_data)); // R2
endmodule

bind doze_ratio_gen doze_ratio_gen_chk #(
  .REG_W(REG_W), .EN_BIT(EN_BIT), .RATIO_LSB(RATIO_LSB), .ROI_BIT(ROI_BIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_rd_data(cfg_rd_data),
  .irq_event(irq_event), .cpu_ce(cpu_ce), .doze_en(doze_en), .roi_arm(roi_arm),
  .ratio_code(ratio_code), .hw_clear(hw_clear)
);

// File: tb/doze_ratio_gen_tb_top.sv
module doze_ratio_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [15:0] cfg_wr_data = '0;
  logic [15:0] cfg_rd_data;
  logic        irq_event = 1'b0;
  logic        cpu_ce;
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  doze_ratio_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .irq_event(irq_event), .cpu_ce(cpu_ce)
  );

  function automatic logic [15:0] word(input bit en, input int code, input bit roi);
    logic [15:0] w = '0;
    w[15]    = roi;
    w[14:12] = code[2:0];
    w[11]    = en;
    return w;
  endfunction

  function automatic bit strobe_due(input int k, input int code);
    int p = 1 << code;
    return (k % p) == (p - 1);
  endfunction

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [15:0] d);
    cfg_wr_en = 1'b1;
    cfg_wr_data = d;
    tick();
    cfg_wr_en = 1'b0;
  endtask

  // compare cycles k0..k0+len-1 against the modulo rule for code
  task automatic run_phase(input int code, input int k0, input int len, input string req);
    for (int k = k0; k < k0 + len; k++) begin
      chk(int'(cpu_ce), int'(strobe_due(k, code)), req);
      tick();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    chk(int'(cfg_rd_data), 0, "R1 reset readback");
    chk(int'(cpu_ce), 1, "R1 reset strobe");
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      chk(int'(cfg_rd_data), 0, "R1 post-reset readback");
      chk(int'(cpu_ce), 1, "R1 post-reset strobe");
      tick();
    end

    // R2 layout and reserved bits
    wr(16'hFFFF);
    chk(int'(cfg_rd_data), int'(word(1, 7, 1)), "R2 all-ones readback");
    wr(16'h0000);
    chk(int'(cfg_rd_data), 0, "R2 clear readback");

    // R3 doze off with every code
    for (int c = 0; c < 8; c++) begin
      wr(word(0, c, 1) | 16'h07FF);
      chk(int'(cfg_rd_data), int'(word(0, c, 1)), "R2 readback doze off");
      for (int k = 0; k < 10; k++) begin
        chk(int'(cpu_ce), 1, "R3 full speed while off");
        tick();
      end
    end

    // R4/R5 sweep every ratio from an off state
    for (int c = 0; c < 8; c++) begin
      wr(word(0, 0, 0));
      wr(word(1, c, 0));
      run_phase(c, 0, 3 * (1 << c), "R4 R5 ratio sweep");
    end

    // R6 ratio change mid-period, both directions
    wr(word(0, 0, 0));
    wr(word(1, 5, 0));
    run_phase(5, 0, 7, "R5 before change");
    wr(word(1, 1, 0));
    run_phase(1, 0, 9, "R6 change to faster");
    wr(word(1, 7, 0));
    run_phase(7, 0, 260, "R6 change to slower");
    wr(word(1, 2, 0));
    run_phase(2, 0, 3, "R6 change again");
    wr(word(1, 0, 0));
    run_phase(0, 0, 5, "R6 change to 1:1");

    // R10 rewrite with same code keeps phase
    wr(word(0, 0, 0));
    wr(word(1, 3, 0));
    run_phase(3, 0, 3, "R10 before rewrite");
    wr(word(1, 3, 1));
    run_phase(3, 4, 14, "R10 after rewrite");

    // R8 interrupt ignored without return-on-interrupt
    wr(word(0, 0, 0));
    wr(word(1, 2, 0));
    for (int k = 0; k < 16; k++) begin
      chk(int'(cpu_ce), int'(strobe_due(k, 2)), "R8 phase across irq");
      irq_event = (k == 5);
      tick();
      irq_event = 1'b0;
    end
    chk(int'(cfg_rd_data), int'(word(1, 2, 0)), "R8 enable kept");

    // R7 return to full speed
    wr(word(0, 0, 0));
    wr(word(1, 4, 1));
    run_phase(4, 0, 6, "R7 before irq");
    irq_event = 1'b1;
    tick();
    irq_event = 1'b0;
    chk(int'(cfg_rd_data), int'(word(0, 4, 1)), "R7 hardware clear readback");
    for (int k = 0; k < 40; k++) begin
      chk(int'(cpu_ce), 1, "R7 full speed after irq");
      tick();
    end

    // R9 write and hardware clear in the same cycle
    wr(word(1, 3, 1));
    chk(int'(cpu_ce), 0, "R5 first cycle at 1:8");
    cfg_wr_en = 1'b1;
    cfg_wr_data = word(1, 5, 1);
    irq_event = 1'b1;
    tick();
    cfg_wr_en = 1'b0;
    irq_event = 1'b0;
    chk(int'(cfg_rd_data), int'(word(0, 5, 1)), "R9 clear wins over write");
    for (int k = 0; k < 8; k++) begin
      chk(int'(cpu_ce), 1, "R9 full speed");
      tick();
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule